// File: doc/BRIEF.md
# Performance Event Counter Unit

This block holds a bank of programmable event counters and one dedicated cycle counter. Software reaches all of them through a small register interface with a 7-bit address. Each event counter advances on its own event pulse input, or by one when software writes a software-increment request. The cycle counter advances on a cycle tick input. A counter moves only when a global enable in the control word and its own enable bit are both set.

A counter that wraps from a value with its top bit set to one with the top bit clear records an overflow in a sticky status register. A level interrupt request is raised while any status bit is set and that counter's interrupt-enable bit is also set. The enable, interrupt-enable and status registers each have a write-one-to-set address and a write-one-to-clear address. Both addresses of a pair read back the same stored value.

Counters can be reached directly by index or through a select register. Event counters take indices 0 to N-1, and the cycle counter always takes index 31. In the enable, interrupt-enable and status registers, bit i belongs to counter i and bit 31 belongs to the cycle counter.

Top module: `evt_counter_unit`

## Requirements
- R1: The parameter `NUM_CTR` (1..31) sets the number of event counters, and any other value stops elaboration. The control word reports `NUM_CTR` in bits [15:11].
- R2: Only control bits 0, 3, 4 and 5 (mask 0x39) are stored. A control read returns those bits ORed with 0x41 in [31:24], 0x00 in [23:16] and N in [15:11]. Bit 0 is the global enable.
- R3: Event counter i increments on `event_pulse[i]` only when control bit 0 and enable bit i are both 1. The cycle counter increments on `cycle_tick` only when control bit 0 and enable bit 31 are both 1.
- R4: The set address (0x01 enable, 0x03 interrupt enable, 0x05 status) ORs in the written bits. The clear address (0x02, 0x04, 0x06) clears the bits written as 1. Both addresses read the stored value. Bits for absent counters stay 0.
- R5: A write to 0x07 adds 1 to every enabled event counter whose bit is 1 in the written data. A read of 0x07 returns 0.
- R6: When an increment takes a counter's bit 31 from 1 to 0, its status bit is set. An increment that leaves bit 31 at 1 does not set it.
- R7: `irq` is high exactly while some counter has both its status bit and its interrupt-enable bit at 1. It stays high until software clears one of them.
- R8: A control write with bit 1 set clears all event counters. A control write with bit 2 set clears the cycle counter. Neither bit is stored.
- R9: Counter values are at 0x20+i and event types at 0x40+i. Address 0x08 holds the select index. Addresses 0x0A (value) and 0x09 (type) act on the selected counter. Value reads return the low 32 bits.
- R10: Addresses 0x0B and 0x0C return the low and high halves of the `EVT_AVAIL` mask. Writes to them change nothing.
- R11: A type write to the cycle counter (index 31) is ignored, and its type always reads 0x11.
- R12: Value or type writes to a nonexistent index (N..30) are ignored, and reads of those indices return 0.
- R13: Reset clears every counter, type, enable, status, select and control bit, so `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Register address for reads and writes |
| wr_data | input | 32 | Write data |
| event_pulse | input | NUM_CTR | One pulse per event, per counter |
| cycle_tick | input | 1 | Cycle counter advance |
| rd_data | output | 32 | Combinational read data at `addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that a single address carries at most one write per cycle. Because of this, a counter is never loaded and cleared in the same cycle, and a set and a clear of the same register never coincide. The stimulus issues one register write per cycle and drives event pulses and ticks only between writes. The interrupt-hold check assumes that only writes to the status-clear or interrupt-clear address can lower the request. The bench performs no other accesses that could do so.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 32;
    localparam int EVT_W    = 10;
    localparam int CYC_IDX  = 31;

    localparam logic [7:0]       IMPL_CODE   = 8'h41;
    localparam logic [7:0]       ID_CODE     = 8'h00;
    localparam logic [5:0]       CTRL_WMASK  = 6'h39;
    localparam logic [EVT_W-1:0] CYCLE_EVENT = EVT_W'(10'h11);

    typedef struct packed {
        logic [7:0] impl;
        logic [7:0] idcode;
        logic [4:0] n;
        logic [4:0] pad;
        logic       bit5;
        logic       bit4;
        logic       div64;
        logic       clr_cyc;
        logic       clr_evt;
        logic       enable;
    } ctrl_t;

    typedef enum logic [3:0] {
        ACC_NONE, ACC_CTRL, ACC_EN_SET, ACC_EN_CLR, ACC_IE_SET, ACC_IE_CLR,
        ACC_OV_SET, ACC_OV_CLR, ACC_SWINC, ACC_SEL, ACC_SEL_TYPE, ACC_SEL_VAL,
        ACC_AVAIL_LO, ACC_AVAIL_HI, ACC_VAL, ACC_TYPE
    } acc_e;

    function automatic acc_e decode(input logic [ADDR_W-1:0] a);
        if (a[6:5] == 2'b01) return ACC_VAL;
        if (a[6:5] == 2'b10) return ACC_TYPE;
        case (a)
            7'h00:   return ACC_CTRL;
            7'h01:   return ACC_EN_SET;
            7'h02:   return ACC_EN_CLR;
            7'h03:   return ACC_IE_SET;
            7'h04:   return ACC_IE_CLR;
            7'h05:   return ACC_OV_SET;
            7'h06:   return ACC_OV_CLR;
            7'h07:   return ACC_SWINC;
            7'h08:   return ACC_SEL;
            7'h09:   return ACC_SEL_TYPE;
            7'h0A:   return ACC_SEL_VAL;
            7'h0B:   return ACC_AVAIL_LO;
            7'h0C:   return ACC_AVAIL_HI;
            default: return ACC_NONE;
        endcase
    endfunction
endpackage

// File: rtl/set_clr_reg.sv
module set_clr_reg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    logic [W-1:0] set_bits, clr_bits;

    assign set_bits = set_we ? wdata : '0;
    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= ((q & ~clr_bits) | set_bits | hw_set) & MASK;
    end

    // R4: bits written to the set address are held afterwards
    assert_set_sticks_R4: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((q & ($past(wdata) & MASK)) == ($past(wdata) & MASK)));
    // R4: absent bits never rise
    assert_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (q & ~MASK) == '0);
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice
    import pmu_pkg::*;
#(
    parameter int               W         = 32,
    parameter bit               HAS_TYPE  = 1'b1,
    parameter logic [EVT_W-1:0] FIXED_EVT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [1:0]       inc,
    input  logic             clr,
    input  logic             ld,
    input  logic [W-1:0]     ld_val,
    input  logic             tp_we,
    input  logic [EVT_W-1:0] tp_val,
    output logic [W-1:0]     value,
    output logic [EVT_W-1:0] evt,
    output logic             ovf
);
    logic [W-1:0]     sum;
    logic [EVT_W-1:0] evt_q;
    logic             bump;

    assign bump = en && (inc != 2'd0) && !ld && !clr;
    assign sum  = value + W'(inc);
    assign ovf  = bump && value[W-1] && !sum[W-1];

    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (ld)   value <= ld_val;
        else if (clr)  value <= '0;
        else if (bump) value <= sum;
    end

    generate
        if (HAS_TYPE) begin : g_type
            always_ff @(posedge clk) begin
                if (rst)        evt_q <= '0;
                else if (tp_we) evt_q <= tp_val;
            end
            assign evt = evt_q;
        end else begin : g_fixed
            assign evt_q = FIXED_EVT;
            assign evt   = evt_q;
        end
    endgenerate

    // R3: with counting off and no load or clear the value holds
    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        (!en && !ld && !clr) |=> (value == $past(value)));
    // R6: an overflow flag is followed by a cleared top bit
    assert_wrap_top_clear_R6: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !value[W-1]);
endmodule

// File: rtl/evt_counter_unit.sv
module evt_counter_unit
    import pmu_pkg::*;
#(
    parameter int          NUM_CTR   = 4,
    parameter int          CTR_W     = 32,
    parameter logic [63:0] EVT_AVAIL = 64'h0000_0003_0000_003F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [6:0]         addr,
    input  logic [31:0]        wr_data,
    input  logic [NUM_CTR-1:0] event_pulse,
    input  logic               cycle_tick,
    output logic [31:0]        rd_data,
    output logic               irq
);
    localparam logic [31:0] IMPL_MASK = ((32'h1 << NUM_CTR) - 32'h1) | 32'h8000_0000;

    generate
        if (NUM_CTR < 1 || NUM_CTR > 31) begin : g_bad_cfg
            $fatal(1, "evt_counter_unit: NUM_CTR must be 1..31");
        end
    endgenerate

    acc_e        acc;
    logic [4:0]  sel_q, tgt_idx;
    logic [5:0]  ctrl_q;
    logic [31:0] cnten_q, inten_q, ovf_q, hw_ovf;
    logic        val_acc, type_acc, ctrl_wr, swinc_wr;
    logic [NUM_CTR-1:0][CTR_W-1:0] ev_cnt;
    logic [NUM_CTR-1:0][EVT_W-1:0] ev_type;
    logic [NUM_CTR-1:0]            ev_ovf;
    logic [CTR_W-1:0]  cyc_cnt;
    logic [EVT_W-1:0]  cyc_type;
    logic              cyc_ovf;
    logic [31:0]       val_rd, type_rd;
    ctrl_t             ctrl_word;

    assign acc      = decode(addr);
    assign val_acc  = (acc == ACC_VAL)  || (acc == ACC_SEL_VAL);
    assign type_acc = (acc == ACC_TYPE) || (acc == ACC_SEL_TYPE);
    assign tgt_idx  = ((acc == ACC_SEL_VAL) || (acc == ACC_SEL_TYPE)) ? sel_q : addr[4:0];
    assign ctrl_wr  = wr_en && (acc == ACC_CTRL);
    assign swinc_wr = wr_en && (acc == ACC_SWINC);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_en && acc == ACC_SEL) sel_q  <= wr_data[4:0];
            if (ctrl_wr)                 ctrl_q <= wr_data[5:0] & CTRL_WMASK;
        end
    end

    // event counters
    generate
        for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
            logic [1:0] inc_i;
            assign inc_i = {1'b0, event_pulse[i]} + {1'b0, swinc_wr && wr_data[i]};
            ctr_slice #(.W(CTR_W), .HAS_TYPE(1'b1), .FIXED_EVT('0)) u_slice (
                .clk(clk), .rst(rst),
                .en(ctrl_q[0] && cnten_q[i]),
                .inc(inc_i),
                .clr(ctrl_wr && wr_data[1]),
                .ld(wr_en && val_acc && tgt_idx == 5'(i)),
                .ld_val(CTR_W'(wr_data)),
                .tp_we(wr_en && type_acc && tgt_idx == 5'(i)),
                .tp_val(wr_data[EVT_W-1:0]),
                .value(ev_cnt[i]), .evt(ev_type[i]), .ovf(ev_ovf[i])
            );
        end
    endgenerate

    // cycle counter, fixed event
    ctr_slice #(.W(CTR_W), .HAS_TYPE(1'b0), .FIXED_EVT(CYCLE_EVENT)) u_cycle (
        .clk(clk), .rst(rst),
        .en(ctrl_q[0] && cnten_q[CYC_IDX]),
        .inc({1'b0, cycle_tick}),
        .clr(ctrl_wr && wr_data[2]),
        .ld(wr_en && val_acc && tgt_idx == 5'(CYC_IDX)),
        .ld_val(CTR_W'(wr_data)),
        .tp_we(1'b0),
        .tp_val(wr_data[EVT_W-1:0]),
        .value(cyc_cnt), .evt(cyc_type), .ovf(cyc_ovf)
    );

    assign hw_ovf = (32'(ev_ovf) | (32'(cyc_ovf) << CYC_IDX)) & IMPL_MASK;

    set_clr_reg #(.W(32), .MASK(IMPL_MASK)) u_cnten (
        .clk(clk), .rst(rst),
        .set_we(wr_en && acc == ACC_EN_SET), .clr_we(wr_en && acc == ACC_EN_CLR),
        .wdata(wr_data), .hw_set('0), .q(cnten_q));
    set_clr_reg #(.W(32), .MASK(IMPL_MASK)) u_inten (
        .clk(clk), .rst(rst),
        .set_we(wr_en && acc == ACC_IE_SET), .clr_we(wr_en && acc == ACC_IE_CLR),
        .wdata(wr_data), .hw_set('0), .q(inten_q));
    set_clr_reg #(.W(32), .MASK(IMPL_MASK)) u_ovf (
        .clk(clk), .rst(rst),
        .set_we(wr_en && acc == ACC_OV_SET), .clr_we(wr_en && acc == ACC_OV_CLR),
        .wdata(wr_data), .hw_set(hw_ovf), .q(ovf_q));

    assign irq = |(ovf_q & inten_q);

    // read path
    always_comb begin
        val_rd  = '0;
        type_rd = '0;
        if (tgt_idx == 5'(CYC_IDX)) begin
            val_rd  = 32'(cyc_cnt);
            type_rd = 32'(cyc_type);
        end
        for (int i = 0; i < NUM_CTR; i++) begin
            if (tgt_idx == 5'(i)) begin
                val_rd  = 32'(ev_cnt[i]);
                type_rd = 32'(ev_type[i]);
            end
        end
    end

    always_comb begin
        ctrl_word        = ctrl_t'(32'(ctrl_q));
        ctrl_word.impl   = IMPL_CODE;
        ctrl_word.idcode = ID_CODE;
        ctrl_word.n      = 5'(NUM_CTR);
    end

    always_comb begin
        case (acc)
            ACC_CTRL:                 rd_data = ctrl_word;
            ACC_EN_SET, ACC_EN_CLR:   rd_data = cnten_q;
            ACC_IE_SET, ACC_IE_CLR:   rd_data = inten_q;
            ACC_OV_SET, ACC_OV_CLR:   rd_data = ovf_q;
            ACC_SEL:                  rd_data = {27'b0, sel_q};
            ACC_AVAIL_LO:             rd_data = EVT_AVAIL[31:0];
            ACC_AVAIL_HI:             rd_data = EVT_AVAIL[63:32];
            ACC_VAL, ACC_SEL_VAL:     rd_data = val_rd;
            ACC_TYPE, ACC_SEL_TYPE:   rd_data = type_rd;
            default:                  rd_data = '0;
        endcase
    end

    // R7: the request only drops after a clear of status or interrupt enable
    assert_irq_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_en && (acc == ACC_OV_CLR || acc == ACC_IE_CLR))) |=> irq);
    // R2: fixed identification fields on every control read
    assert_ctrl_id_R2: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_CTRL) |-> (rd_data[31:11] == {IMPL_CODE, ID_CODE, 5'(NUM_CTR)}));
    // R5: software increment register reads as zero
    assert_swinc_raz_R5: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_SWINC) |-> (rd_data == 32'h0));
    // R11: cycle counter type never moves
    assert_cycle_type_R11: assert property (@(posedge clk) disable iff (rst)
        (val_acc || type_acc) && (tgt_idx == 5'(CYC_IDX)) |-> (type_rd == 32'h11));
endmodule

// File: tb/tb_evt_counter_unit.sv
module tb_evt_counter_unit;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [6:0]   addr;
    logic [31:0]  wr_data;
    logic [N-1:0] event_pulse;
    logic         cycle_tick;
    logic [31:0]  rd_data;
    logic         irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    evt_counter_unit #(.NUM_CTR(N), .CTR_W(32), .EVT_AVAIL(64'h0000_0003_0000_003F)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .event_pulse(event_pulse), .cycle_tick(cycle_tick),
        .rd_data(rd_data), .irq(irq));

    typedef struct packed {
        logic [6:0]  wa;
        logic [31:0] wd;
        logic [6:0]  ra;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{7'h00, 32'h0000_00FF, 7'h00, 32'h4100_2039, 4'd2},  // R2 writable mask, R1 count field
        '{7'h00, 32'h0000_0001, 7'h00, 32'h4100_2001, 4'd2},  // R2
        '{7'h01, 32'h8000_0005, 7'h02, 32'h8000_0005, 4'd4},  // R4 set, read via clear addr
        '{7'h02, 32'h0000_0004, 7'h01, 32'h8000_0001, 4'd4},  // R4 clear
        '{7'h01, 32'h0000_00F0, 7'h01, 32'h8000_0001, 4'd4},  // R4 absent bits stay 0
        '{7'h03, 32'h8000_0003, 7'h04, 32'h8000_0003, 4'd4},  // R4 interrupt enable
        '{7'h21, 32'h0000_1234, 7'h21, 32'h0000_1234, 4'd9},  // R9 direct value
        '{7'h08, 32'h0000_0002, 7'h08, 32'h0000_0002, 4'd9},  // R9 select
        '{7'h0A, 32'h0000_ABCD, 7'h22, 32'h0000_ABCD, 4'd9},  // R9 indirect value
        '{7'h25, 32'h0000_0055, 7'h25, 32'h0000_0000, 4'd12}, // R12 absent value
        '{7'h40, 32'h0000_0008, 7'h40, 32'h0000_0008, 4'd9},  // R9 direct type
        '{7'h5F, 32'h0000_0003, 7'h5F, 32'h0000_0011, 4'd11}, // R11 cycle type fixed
        '{7'h0B, 32'h0000_FFFF, 7'h0B, 32'h0000_003F, 4'd10}, // R10 low half
        '{7'h0C, 32'h0000_0000, 7'h0C, 32'h0000_0003, 4'd10}, // R10 high half
        '{7'h07, 32'h0000_0000, 7'h07, 32'h0000_0000, 4'd5},  // R5 reads zero
        '{7'h45, 32'h0000_0007, 7'h45, 32'h0000_0000, 4'd12}  // R12 absent type
    };

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic chk(input logic [6:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #1;
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    task automatic pulse(input logic [N-1:0] m, input int n);
        @(negedge clk);
        event_pulse = m;
        repeat (n) @(negedge clk);
        event_pulse = '0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        cycle_tick = 1'b1;
        repeat (n) @(negedge clk);
        cycle_tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0;
        event_pulse = '0; cycle_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 reset state, R1 counter count in control word
        chk(7'h00, 32'h4100_2000, "R13_R1");
        chk(7'h01, 32'h0, "R13");
        chk_irq(1'b0, "R13");

        for (int k = 0; k < NV; k++) begin
            wr(VECS[k].wa, VECS[k].wd);
            chk(VECS[k].ra, VECS[k].exp, $sformatf("R%0d vec%0d", VECS[k].req, k));
        end

        // R5 software increment hits enabled counter 0 only
        wr(7'h07, 32'h0000_0007);
        chk(7'h20, 32'h1, "R5");
        chk(7'h21, 32'h1234, "R3 disabled ignores swinc");
        chk(7'h22, 32'hABCD, "R3 disabled ignores swinc");

        // R3 event counting when enabled
        wr(7'h01, 32'h2);
        pulse(4'b0010, 3);
        chk(7'h21, 32'h1237, "R3");

        // R3 global enable off blocks counting
        wr(7'h00, 32'h0);
        pulse(4'b0001, 2);
        chk(7'h20, 32'h1, "R3 global off");
        wr(7'h00, 32'h1);

        // R6 R7 overflow with interrupt enabled
        wr(7'h20, 32'hFFFF_FFFF);
        pulse(4'b0001, 1);
        chk(7'h20, 32'h0, "R6 wrap");
        chk(7'h05, 32'h1, "R6 status");
        chk_irq(1'b1, "R7 raise");
        wr(7'h06, 32'h1);
        chk(7'h05, 32'h0, "R4 status clear");
        chk_irq(1'b0, "R7 drop");

        // R7 overflow without interrupt enable
        wr(7'h01, 32'h4);
        wr(7'h22, 32'hFFFF_FFFF);
        pulse(4'b0100, 1);
        chk(7'h05, 32'h4, "R6 status bit2");
        chk_irq(1'b0, "R7 masked");

        // R6 no overflow when top bit rises
        wr(7'h21, 32'h7FFF_FFFF);
        pulse(4'b0010, 1);
        chk(7'h21, 32'h8000_0000, "R6 rise");
        chk(7'h05, 32'h4, "R6 no new status");

        // R3 R6 R7 cycle counter
        wr(7'h3F, 32'hFFFF_FFFE);
        ticks(2);
        chk(7'h3F, 32'h0, "R3 cycle wrap");
        chk(7'h05, 32'h8000_0004, "R6 cycle status");
        chk_irq(1'b1, "R7 cycle");

        // R8 event clear leaves cycle counter
        wr(7'h3F, 32'h5);
        wr(7'h00, 32'h3);
        chk(7'h20, 32'h0, "R8 evt clear");
        chk(7'h21, 32'h0, "R8 evt clear");
        chk(7'h22, 32'h0, "R8 evt clear");
        chk(7'h3F, 32'h5, "R8 cycle kept");
        chk(7'h00, 32'h4100_2001, "R8 not stored");
        wr(7'h00, 32'h5);
        chk(7'h3F, 32'h0, "R8 cycle clear");

        // R7 software set of status
        wr(7'h06, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R7 all clear");
        wr(7'h05, 32'h2);
        chk_irq(1'b1, "R7 sw set");

        // R13 reset mid-run
        do_reset();
        chk(7'h00, 32'h4100_2000, "R13 ctrl");
        chk(7'h01, 32'h0, "R13 enable");
        chk(7'h21, 32'h0, "R13 counter");
        chk(7'h40, 32'h0, "R13 type");
        chk_irq(1'b0, "R13 irq");

        finish_run();
    end
endmodule